// File: doc/BRIEF.md
# Register Bank Prefix Decoder

This block sits in an instruction decode path. It watches a stream of 16-bit instruction words and picks out a bank-select prefix word. From that prefix it keeps three 2-bit fields: a source-bank field, a second-operand bank field and a bundle-length code. These fields apply to the one instruction that follows the prefix. For that instruction, the block turns the 3-bit architectural register numbers of its two operands into physical register numbers. Each operand is tagged as either an address register or a data register. There are two address banks of eight registers (16 physical) and four data banks of eight registers (32 physical).

Every accepted word produces one registered result in the next cycle. A prefix reports the total bundle length in bytes, which counts the 2-byte prefix plus the opcode. An instruction reports the two physical indices. If a prefix asks for an address bank that does not exist, or if two prefixes arrive back to back, the result is marked illegal. After one instruction has used a prefix, the mapping returns to bank 0. Instruction execution, register storage and fetch belong to other blocks.

Top module: `regbank_prefix_unit`

## Requirements
- R1: A valid word is a prefix exactly when (word & 0xFF30) == 0x7100. A prefix gives `res_is_prefix`=1 one cycle later. Any other valid word is treated as an instruction and gives `res_is_prefix`=0.
- R2: For a prefix, `res_bundle_bytes` one cycle later depends on the size code in bits 7:6: 0→4, 1→6, 2→8, 3→10. The instruction that uses the prefix reports the same value. An instruction with no prefix before it reports 0. Example: 0x7180 gives 8 bytes.
- R3: For a data operand (kind 0), the physical index is bank×8 + index, as a 5-bit value. The source operand takes its bank from prefix bits 3:2. The second operand takes its bank from prefix bits 1:0. Example: 0x7181 puts the second operand in bank 1.
- R4: For an address operand (kind 1), the physical index is bank×8 + index with the bank in {0,1}, so bit 4 of the result is always 0. A bank field of 2 or 3 on an address operand sets `res_illegal` and maps that operand to bank 0.
- R5: A prefix applies only to the next instruction. Every later instruction maps through bank 0 and reports a bundle length of 0, until a new prefix arrives.
- R6: A prefix that comes right after another prefix, with no instruction between them, sets `res_illegal` on its own result. The second prefix's fields replace the first's.
- R7: While reset is held, and in the cycle after reset, `res_valid`, `res_is_prefix`, `res_illegal`, both indices and the bundle length are all 0. No prefix is pending.
- R8: A cycle with `word_valid`=0 gives `res_valid`=0 one cycle later and leaves any pending prefix in place for the next instruction.
- R9: The prefix 0x7100, with all fields zero, leaves the mapping of the next instruction the same as having no prefix. It still reports a 4-byte bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | An instruction word is present this cycle |
| word_in | input | 16 | Instruction word |
| src_kind | input | 1 | Source operand file: 0 data, 1 address |
| src_idx | input | 3 | Source architectural register index |
| dst_kind | input | 1 | Second operand file: 0 data, 1 address |
| dst_idx | input | 3 | Second operand architectural register index |
| res_valid | output | 1 | A result for the word of the previous cycle |
| res_is_prefix | output | 1 | That word was a prefix |
| res_illegal | output | 1 | Invalid address bank or back-to-back prefix |
| res_src_phys | output | 5 | Physical source register index |
| res_dst_phys | output | 5 | Physical second-operand register index |
| res_bundle_bytes | output | 4 | Bundle length in bytes, 0 if no prefix |

## Verification
Near-miss words, such as those with bit 4, bit 9 or bit 11 set, check that the mask does not accept them as prefixes. The exact words 0x7100, 0x7180 and 0x7181 pin down the size code and which field feeds which operand. Directed sequences cover prefix then instruction then instruction, prefix then prefix, and prefix then idle then instruction. These sequences tell apart one-shot use, replacement and holding of the pending prefix. A seeded random stream that mixes prefixes, instructions, idle cycles and both operand kinds is checked against a bench model, to catch mistakes in how the address and data banks interact.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

    localparam int WORD_W   = 16;
    localparam int BANK_W   = 2;
    localparam logic [WORD_W-1:0] PFX_MASK = 16'hFF30;
    localparam logic [WORD_W-1:0] PFX_BASE = 16'h7100;

    typedef enum logic {
        OPND_DATA = 1'b0,
        OPND_ADDR = 1'b1
    } opnd_kind_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank_src;
        logic [BANK_W-1:0] bank_dst;
        logic [1:0]        size_code;
    } pfx_fields_t;

    function automatic logic is_prefix_word(input logic [WORD_W-1:0] w);
        return (w & PFX_MASK) == PFX_BASE;
    endfunction

    function automatic logic [3:0] bundle_bytes(input logic [1:0] code);
        return 4'd4 + {1'b0, code, 1'b0};
    endfunction

endpackage

// File: rtl/rbp_prefix_detect.sv
module rbp_prefix_detect
    import rbp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              hit,
    output pfx_fields_t       fields
);
    always_comb begin
        hit              = is_prefix_word(word);
        fields.size_code = word[7:6];
        fields.bank_src  = word[3:2];
        fields.bank_dst  = word[1:0];
    end
endmodule

// File: rtl/rbp_bank_state.sv
module rbp_bank_state
    import rbp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic        consume,
    input  pfx_fields_t fields_in,
    output logic        pend_valid,
    output pfx_fields_t pend_fields
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid  <= 1'b0;
            pend_fields <= '0;
        end else if (load) begin
            pend_valid  <= 1'b1;
            pend_fields <= fields_in;
        end else if (consume) begin
            pend_valid  <= 1'b0;
            pend_fields <= '0;
        end
    end

    // R5
    revert_after_use_chk: assert property (@(posedge clk) disable iff (rst)
        (consume && !load) |=> !pend_valid);

    // R6
    replace_on_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (pend_valid && pend_fields == $past(fields_in)));
endmodule

// File: rtl/rbp_index_map.sv
module rbp_index_map
    import rbp_pkg::*;
#(
    parameter int IDX_W      = 3,
    parameter int DATA_BANKS = 4,
    parameter int ADDR_BANKS = 2,
    parameter int PHYS_W     = $clog2(DATA_BANKS) + IDX_W
) (
    input  opnd_kind_e        kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic              use_bank,
    input  logic [BANK_W-1:0] bank,
    output logic [PHYS_W-1:0] phys,
    output logic              bad_bank
);
    logic [BANK_W-1:0] eff_bank;
    int                limit;

    always_comb begin
        limit    = (kind == OPND_ADDR) ? ADDR_BANKS : DATA_BANKS;
        bad_bank = use_bank && (int'(bank) >= limit);
        eff_bank = (use_bank && !bad_bank) ? bank : '0;
        phys     = (PHYS_W'(eff_bank) << IDX_W) | PHYS_W'(idx);
    end
endmodule

// File: rtl/regbank_prefix_unit.sv
module regbank_prefix_unit
    import rbp_pkg::*;
#(
    parameter int IDX_W      = 3,
    parameter int DATA_BANKS = 4,
    parameter int ADDR_BANKS = 2,
    localparam int PHYS_W    = $clog2(DATA_BANKS) + IDX_W,
    localparam int ADDR_PW   = $clog2(ADDR_BANKS) + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [15:0]       word_in,
    input  logic              src_kind,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic              dst_kind,
    input  logic [IDX_W-1:0]  dst_idx,
    output logic              res_valid,
    output logic              res_is_prefix,
    output logic              res_illegal,
    output logic [PHYS_W-1:0] res_src_phys,
    output logic [PHYS_W-1:0] res_dst_phys,
    output logic [3:0]        res_bundle_bytes
);
    localparam int N_OPND = 2;

    logic        pfx_hit;
    pfx_fields_t pfx_fields;
    logic        take_pfx;
    logic        take_instr;
    logic        pend_valid;
    pfx_fields_t pend_fields;

    opnd_kind_e        op_kind [N_OPND];
    logic [IDX_W-1:0]  op_idx  [N_OPND];
    logic [BANK_W-1:0] op_bank [N_OPND];
    logic [PHYS_W-1:0] op_phys [N_OPND];
    logic              op_bad  [N_OPND];

    rbp_prefix_detect u_detect (
        .word   (word_in),
        .hit    (pfx_hit),
        .fields (pfx_fields)
    );

    assign take_pfx   = word_valid && pfx_hit;
    assign take_instr = word_valid && !pfx_hit;

    rbp_bank_state u_state (
        .clk         (clk),
        .rst         (rst),
        .load        (take_pfx),
        .consume     (take_instr),
        .fields_in   (pfx_fields),
        .pend_valid  (pend_valid),
        .pend_fields (pend_fields)
    );

    always_comb begin
        op_kind[0] = opnd_kind_e'(src_kind);
        op_idx[0]  = src_idx;
        op_bank[0] = pend_fields.bank_src;
        op_kind[1] = opnd_kind_e'(dst_kind);
        op_idx[1]  = dst_idx;
        op_bank[1] = pend_fields.bank_dst;
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_map
        rbp_index_map #(
            .IDX_W      (IDX_W),
            .DATA_BANKS (DATA_BANKS),
            .ADDR_BANKS (ADDR_BANKS),
            .PHYS_W     (PHYS_W)
        ) u_map (
            .kind     (op_kind[g]),
            .idx      (op_idx[g]),
            .use_bank (pend_valid),
            .bank     (op_bank[g]),
            .phys     (op_phys[g]),
            .bad_bank (op_bad[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid        <= 1'b0;
            res_is_prefix    <= 1'b0;
            res_illegal      <= 1'b0;
            res_src_phys     <= '0;
            res_dst_phys     <= '0;
            res_bundle_bytes <= '0;
        end else begin
            res_valid <= word_valid;
            if (take_pfx) begin
                res_is_prefix    <= 1'b1;
                res_illegal      <= pend_valid;
                res_src_phys     <= '0;
                res_dst_phys     <= '0;
                res_bundle_bytes <= bundle_bytes(pfx_fields.size_code);
            end else if (take_instr) begin
                res_is_prefix    <= 1'b0;
                res_illegal      <= op_bad[0] || op_bad[1];
                res_src_phys     <= op_phys[0];
                res_dst_phys     <= op_phys[1];
                res_bundle_bytes <= pend_valid ? bundle_bytes(pend_fields.size_code) : 4'd0;
            end else begin
                res_is_prefix    <= 1'b0;
                res_illegal      <= 1'b0;
                res_src_phys     <= '0;
                res_dst_phys     <= '0;
                res_bundle_bytes <= '0;
            end
        end
    end

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_illegal && res_bundle_bytes == 4'd0));

    // R6
    double_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        (take_pfx && pend_valid) |=> (res_is_prefix && res_illegal));

    // R2
    bundle_len_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_is_prefix) |->
            (res_bundle_bytes >= 4'd4 && res_bundle_bytes <= 4'd10 && !res_bundle_bytes[0]));

    // R4
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (take_instr && src_kind) |=> (res_src_phys < PHYS_W'(1 << ADDR_PW)));

    // R5
    no_prefix_len_chk: assert property (@(posedge clk) disable iff (rst)
        (take_instr && !pend_valid) |=> (res_bundle_bytes == 4'd0 && !res_illegal));

    // R8
    idle_result_chk: assert property (@(posedge clk) disable iff (rst)
        !word_valid |=> !res_valid);
endmodule

// File: tb/sim_regbank_prefix_unit.sv
module sim_regbank_prefix_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       word_valid = 1'b0;
    logic [15:0] word_in = '0;
    logic       src_kind = 1'b0;
    logic [2:0] src_idx = '0;
    logic       dst_kind = 1'b0;
    logic [2:0] dst_idx = '0;
    logic       res_valid, res_is_prefix, res_illegal;
    logic [4:0] res_src_phys, res_dst_phys;
    logic [3:0] res_bundle_bytes;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic       m_pend = 1'b0;
    logic [1:0] m_a = '0, m_b = '0, m_sz = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbank_prefix_unit u0 (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word_in(word_in),
        .src_kind(src_kind), .src_idx(src_idx), .dst_kind(dst_kind), .dst_idx(dst_idx),
        .res_valid(res_valid), .res_is_prefix(res_is_prefix), .res_illegal(res_illegal),
        .res_src_phys(res_src_phys), .res_dst_phys(res_dst_phys),
        .res_bundle_bytes(res_bundle_bytes)
    );

    function automatic logic [3:0] exp_len(input logic [1:0] c);
        case (c)
            2'd0: return 4'd4;
            2'd1: return 4'd6;
            2'd2: return 4'd8;
            default: return 4'd10;
        endcase
    endfunction

    function automatic logic [4:0] exp_phys(input logic kind, input logic [2:0] idx,
                                            input logic pend, input logic [1:0] bank,
                                            output logic bad);
        int b;
        b = pend ? int'(bank) : 0;
        bad = 1'b0;
        if (kind && b > 1) begin
            bad = 1'b1;
            b = 0;
        end
        return 5'(b * 8 + int'(idx));
    endfunction

    task automatic step(input string tag, input logic v, input logic [15:0] w,
                        input logic sk, input logic [2:0] si,
                        input logic dk, input logic [2:0] di);
        logic e_pfx, e_ill, bs, bd;
        logic [4:0] e_s, e_d;
        logic [3:0] e_len;
        @(negedge clk);
        word_valid = v; word_in = w;
        src_kind = sk; src_idx = si; dst_kind = dk; dst_idx = di;
        e_pfx = 0; e_ill = 0; e_s = 0; e_d = 0; e_len = 0;
        if (v && ((w & 16'hFF30) == 16'h7100)) begin
            e_pfx = 1; e_ill = m_pend; e_len = exp_len(w[7:6]);
            m_pend = 1; m_a = w[3:2]; m_b = w[1:0]; m_sz = w[7:6];
        end else if (v) begin
            e_s = exp_phys(sk, si, m_pend, m_a, bs);
            e_d = exp_phys(dk, di, m_pend, m_b, bd);
            e_ill = bs | bd;
            e_len = m_pend ? exp_len(m_sz) : 4'd0;
            m_pend = 0;
        end
        @(posedge clk);
        #1;
        checks++;
        if (res_valid !== v || res_is_prefix !== e_pfx || res_illegal !== e_ill ||
            res_src_phys !== e_s || res_dst_phys !== e_d || res_bundle_bytes !== e_len) begin
            errors++;
            $display("FAIL %s: got v=%0b p=%0b ill=%0b s=%0d d=%0d len=%0d exp v=%0b p=%0b ill=%0b s=%0d d=%0d len=%0d",
                     tag, res_valid, res_is_prefix, res_illegal, res_src_phys, res_dst_phys,
                     res_bundle_bytes, v, e_pfx, e_ill, e_s, e_d, e_len);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [15:0] w;
        void'($urandom(32'h5EED));
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        // R7 reset state
        if (res_valid !== 0 || res_illegal !== 0 || res_is_prefix !== 0 ||
            res_src_phys !== 0 || res_dst_phys !== 0 || res_bundle_bytes !== 0) begin
            errors++;
            $display("FAIL R7: got v=%0b ill=%0b len=%0d exp all zero",
                     res_valid, res_illegal, res_bundle_bytes);
        end
        @(negedge clk); rst = 0;

        step("R7_after_reset", 0, 16'h0000, 0, 0, 0, 0);
        // R1 near misses and exact match
        step("R1_bit4", 1, 16'h7110, 0, 3, 0, 4);
        step("R1_bit9", 1, 16'h7300, 0, 1, 0, 2);
        step("R1_bit11", 1, 16'h7900, 0, 1, 0, 2);
        // R2 0x7180 -> 8 bytes, then R9-ish bank0 mapping
        step("R2_7180", 1, 16'h7180, 0, 0, 0, 0);
        step("R2_instr_len", 1, 16'h1234, 0, 5, 0, 6);
        // R3 0x7181: dst in data bank 1
        step("R3_7181", 1, 16'h7181, 0, 0, 0, 0);
        step("R3_dst_bank1", 1, 16'h2000, 0, 2, 0, 7);
        // R3 src bank 3 data, dst bank 2
        step("R3_pfx", 1, 16'h710E, 0, 0, 0, 0);
        step("R3_data_banks", 1, 16'h2000, 0, 7, 0, 1);
        // R5 revert
        step("R5_revert", 1, 16'h2000, 0, 7, 0, 1);
        // R4 address bank 1 legal, then bank 2 illegal
        step("R4_pfx", 1, 16'h7105, 0, 0, 0, 0);
        step("R4_addr_bank1", 1, 16'h4000, 1, 5, 1, 3);
        step("R4_pfx2", 1, 16'h71CA, 0, 0, 0, 0);
        step("R4_addr_bad", 1, 16'h4000, 1, 5, 0, 3);
        // R6 back to back, second replaces
        step("R6_first", 1, 16'h710F, 0, 0, 0, 0);
        step("R6_second", 1, 16'h7144, 0, 0, 0, 0);
        step("R6_replaced", 1, 16'h3000, 0, 2, 0, 2);
        // R8 idle keeps pending
        step("R8_pfx", 1, 16'h71C9, 0, 0, 0, 0);
        step("R8_idle", 0, 16'h71FF, 0, 0, 0, 0);
        step("R8_use", 1, 16'h3000, 0, 6, 1, 6);
        // R9 0x7100 no change
        step("R9_pfx", 1, 16'h7100, 0, 0, 0, 0);
        step("R9_instr", 1, 16'h3000, 1, 4, 0, 3);
        // R2 all size codes
        for (int c = 0; c < 4; c++) begin
            step("R2_size", 1, 16'h7100 | 16'(c << 6), 0, 0, 0, 0);
            step("R2_size_instr", 1, 16'h0000, 0, 1, 1, 1);
        end
        // random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r < 4) w = 16'h7100 | 16'($urandom_range(0, 255) & 8'hCF);
            else w = 16'($urandom);
            step("R3_R4_random", (r != 9), w, 1'($urandom), 3'($urandom),
                 1'($urandom), 3'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule